// File: doc/BRIEF.md
# Iterative Feistel Cipher Round Sequencer

This block sequences one shared datapath for a 128-bit Feistel block cipher that accepts 128-, 192- and 256-bit keys. A single start pulse latches the key-length select, the direction, the key and the input block. The block then steps through four kinds of phase, one per clock cycle: an input whitening, the Feistel rounds, a mixing layer after each complete group of six rounds except the final group, and an output whitening. Each layer sends one half through a forward transform and the other half through the inverse transform. In every cycle the block presents the phase, the round number, the subkey index and a half-swap flag, which is what a real round engine needs to pick its operation and its key.

Decryption uses the same sequence. The subkey index runs in the reverse order, and the keys given to the forward and inverse transforms in each mixing layer trade places. The subkeys come from the latched key and the current index in the same cycle, so no key table is stored. The real round function, substitution tables, mixing-layer arithmetic and key expansion are replaced here by simple invertible stand-ins. These are enough to show that decrypting a ciphertext returns the plaintext.

Top module: `feistel_round_seq`

## Requirements
- R1: While reset is asserted and after reset, with no start given, phase_o reads 0 (idle), done_o is 0, round_o is 0 and data_o is 0.
- R2: Phase codes are 0 idle, 1 input whitening, 2 round, 3 mixing layer and 4 output whitening. key_len_i 0 selects 18 rounds. Codes 1, 2 and 3 select 24 rounds. An accepted operation is active for rounds + rounds/6 + 1 cycles: 22 or 29.
- R3: Whitening takes the first active cycle. A mixing-layer cycle follows round 6 and round 12, and for 24 rounds also round 18. None follows the final round. round_o shows the current round during round cycles and the round just finished during a mixing-layer cycle. It is 0 during input whitening and equals the final round during output whitening.
- R4: In encryption (decrypt_i = 0) sk_idx_o counts 0, 1, 2 and so on, one step per active cycle. In decryption it counts down from the active length minus one to 0.
- R5: half_swap_o is 1 in every round cycle except the final round, and 0 in all other cycles.
- R6: A start pulse is taken only in the idle phase. A pulse during an operation, including its output-whitening cycle, starts nothing and does not change the result. Key length, direction, key and data are latched at start, and later changes to those inputs have no effect.
- R7: Encrypting a block and then decrypting the result with the same key and key length returns the original block, for every key length. The ciphertext differs from the plaintext.
- R8: With key_len_i 0, key_i[255:128] does not affect the result. With key_len_i 1, key_i[255:192] does not affect the result.
- R9: done_o is a one-cycle pulse in the cycle after output whitening. data_o then holds the result until the next accepted start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Start pulse, taken only when idle |
| key_len_i | input | 2 | Key length: 0 = 128, 1 = 192, 2 or 3 = 256 bits |
| decrypt_i | input | 1 | 0 encrypt, 1 decrypt |
| key_i | input | 256 | Cipher key, low-aligned |
| data_i | input | 128 | Input block |
| phase_o | output | 3 | Current phase code |
| round_o | output | 5 | Round number |
| sk_idx_o | output | 5 | Subkey index for this cycle |
| half_swap_o | output | 1 | Halves exchanged at the end of this round |
| done_o | output | 1 | Result valid pulse |
| data_o | output | 128 | Result block |

## Verification
The bench works out the whole expected phase, round, index and swap sequence for each key length, and compares it cycle by cycle. A mixing layer placed one round off, or one missing after round 18 for long keys, breaks both that sequence and the cycle count. A decrypt index that is off by one, or mixing-layer keys left unswapped, shows up as a failed round trip. Start pulses in the middle of an operation and in its output-whitening cycle catch a sequencer that restarts or chains operations. Inputs changed after start, and the unused upper key bits, catch a design that reads live inputs or fails to mask the key.

// File: rtl/feistel_seq_pkg.sv
package feistel_seq_pkg;

  localparam int BLK_W  = 128;
  localparam int HALF_W = BLK_W / 2;
  localparam int KEY_W  = 256;

  typedef enum logic [2:0] {
    PH_IDLE = 3'd0,
    PH_PRE  = 3'd1,
    PH_RND  = 3'd2,
    PH_FL   = 3'd3,
    PH_POST = 3'd4
  } phase_e;

  function automatic logic [HALF_W-1:0] rotl_h(input logic [HALF_W-1:0] x, input int amt);
    int s;
    s = amt % HALF_W;
    if (s == 0) return x;
    return (x << s) | (x >> (HALF_W - s));
  endfunction

  function automatic logic [HALF_W-1:0] rotr_h(input logic [HALF_W-1:0] x, input int amt);
    return rotl_h(x, HALF_W - (amt % HALF_W));
  endfunction

  // stand-in round function
  function automatic logic [HALF_W-1:0] mix_f(input logic [HALF_W-1:0] x, input logic [HALF_W-1:0] k);
    logic [HALF_W-1:0] y;
    y = x ^ k;
    return (rotl_h(y, 13) + (y >> 7)) ^ rotl_h(k, 29);
  endfunction

  function automatic logic [HALF_W-1:0] fl_fwd(input logic [HALF_W-1:0] x, input logic [HALF_W-1:0] k);
    return rotl_h(x, 1) ^ k;
  endfunction

  function automatic logic [HALF_W-1:0] fl_inv(input logic [HALF_W-1:0] y, input logic [HALF_W-1:0] k);
    return rotr_h(y ^ k, 1);
  endfunction

  function automatic logic [KEY_W-1:0] key_mask(input logic [1:0] klen);
    case (klen)
      2'd0:    return {{(KEY_W/2){1'b0}}, {(KEY_W/2){1'b1}}};
      2'd1:    return {{(KEY_W/4){1'b0}}, {(3*KEY_W/4){1'b1}}};
      default: return {KEY_W{1'b1}};
    endcase
  endfunction

endpackage

// File: rtl/fs_seq_ctrl.sv
module fs_seq_ctrl
  import feistel_seq_pkg::*;
#(
  parameter int GRP   = 6,
  parameter int RND_S = 18,
  parameter int RND_L = 24,
  parameter int RND_W = 5,
  parameter int IDX_W = 5
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic [1:0]       key_len_i,
  input  logic             decrypt_i,
  output phase_e           phase_o,
  output logic [RND_W-1:0] round_o,
  output logic [IDX_W-1:0] sk_idx_o,
  output logic             half_swap_o,
  output logic             done_o,
  output logic             load_o,
  output logic             dec_o
);

  localparam int T_S = RND_S + RND_S / GRP + 1;
  localparam int T_L = RND_L + RND_L / GRP + 1;

  phase_e           ph_q;
  logic [RND_W-1:0] rnd_q, n_rnd_q, grp_q;
  logic [IDX_W-1:0] step_q, t_last_q;
  logic             dec_q, done_q;
  logic             long_key;

  assign long_key = (key_len_i != 2'd0);
  assign load_o   = (ph_q == PH_IDLE) && start_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ph_q     <= PH_IDLE;
      rnd_q    <= '0;
      n_rnd_q  <= '0;
      grp_q    <= '0;
      step_q   <= '0;
      t_last_q <= '0;
      dec_q    <= 1'b0;
      done_q   <= 1'b0;
    end else begin
      done_q <= 1'b0;
      case (ph_q)
        PH_IDLE: if (start_i) begin
          ph_q     <= PH_PRE;
          dec_q    <= decrypt_i;
          n_rnd_q  <= long_key ? RND_W'(RND_L) : RND_W'(RND_S);
          t_last_q <= long_key ? IDX_W'(T_L - 1) : IDX_W'(T_S - 1);
          rnd_q    <= '0;
          grp_q    <= '0;
          step_q   <= '0;
        end
        PH_PRE: begin
          ph_q   <= PH_RND;
          rnd_q  <= RND_W'(1);
          grp_q  <= RND_W'(1);
          step_q <= step_q + 1'b1;
        end
        PH_RND: begin
          step_q <= step_q + 1'b1;
          if (rnd_q == n_rnd_q) begin
            ph_q <= PH_POST;
          end else if (grp_q == RND_W'(GRP)) begin
            ph_q <= PH_FL;
          end else begin
            rnd_q <= rnd_q + 1'b1;
            grp_q <= grp_q + 1'b1;
          end
        end
        PH_FL: begin
          ph_q   <= PH_RND;
          rnd_q  <= rnd_q + 1'b1;
          grp_q  <= RND_W'(1);
          step_q <= step_q + 1'b1;
        end
        PH_POST: begin
          ph_q   <= PH_IDLE;
          done_q <= 1'b1;
          rnd_q  <= '0;
          step_q <= '0;
        end
        default: ph_q <= PH_IDLE;
      endcase
    end
  end

  assign phase_o     = ph_q;
  assign round_o     = rnd_q;
  assign sk_idx_o    = dec_q ? (t_last_q - step_q) : step_q;
  assign half_swap_o = (ph_q == PH_RND) && (rnd_q != n_rnd_q);
  assign done_o      = done_q;
  assign dec_o       = dec_q;

endmodule

// File: rtl/fs_subkey.sv
module fs_subkey
  import feistel_seq_pkg::*;
#(
  parameter int IDX_W = 5
) (
  input  logic [KEY_W-1:0] key_i,
  input  logic [IDX_W-1:0] idx_i,
  output logic [BLK_W-1:0] sk_o
);

  logic [HALF_W-1:0] ka, kb;

  // fold upper key quarter pairs onto the lower ones
  assign ka = key_i[HALF_W-1:0]      ^ key_i[3*HALF_W-1:2*HALF_W];
  assign kb = key_i[2*HALF_W-1:HALF_W] ^ key_i[4*HALF_W-1:3*HALF_W];

  always_comb begin
    sk_o[BLK_W-1:HALF_W] = rotl_h(ka, int'(idx_i) + 1) ^ HALF_W'(idx_i);
    sk_o[HALF_W-1:0]     = rotl_h(kb, 2 * int'(idx_i) + 3) ^ ~HALF_W'(idx_i);
  end

endmodule

// File: rtl/fs_round_dp.sv
module fs_round_dp
  import feistel_seq_pkg::*;
(
  input  logic [BLK_W-1:0] state_i,
  input  logic [BLK_W-1:0] sk_i,
  input  phase_e           phase_i,
  input  logic             swap_i,
  input  logic             dec_i,
  output logic [BLK_W-1:0] next_o
);

  logic [HALF_W-1:0] lh, rh, r_mix, k_fwd, k_inv;

  assign lh    = state_i[BLK_W-1:HALF_W];
  assign rh    = state_i[HALF_W-1:0];
  assign r_mix = rh ^ mix_f(lh, sk_i[HALF_W-1:0]);
  // decryption trades the layer keys between the two halves
  assign k_fwd = dec_i ? sk_i[HALF_W-1:0] : sk_i[BLK_W-1:HALF_W];
  assign k_inv = dec_i ? sk_i[BLK_W-1:HALF_W] : sk_i[HALF_W-1:0];

  always_comb begin
    case (phase_i)
      PH_PRE, PH_POST: next_o = state_i ^ sk_i;
      PH_RND:          next_o = swap_i ? {r_mix, lh} : {lh, r_mix};
      PH_FL:           next_o = {fl_fwd(lh, k_fwd), fl_inv(rh, k_inv)};
      default:         next_o = state_i;
    endcase
  end

endmodule

// File: rtl/feistel_round_seq.sv
module feistel_round_seq
  import feistel_seq_pkg::*;
#(
  parameter int  GRP_LEN   = 6,
  parameter int  RND_SHORT = 18,
  parameter int  RND_LONG  = 24,
  localparam int T_LONG    = RND_LONG + RND_LONG / GRP_LEN + 1,
  localparam int RND_W     = $clog2(RND_LONG + 1),
  localparam int IDX_W     = $clog2(T_LONG)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic [1:0]       key_len_i,
  input  logic             decrypt_i,
  input  logic [KEY_W-1:0] key_i,
  input  logic [BLK_W-1:0] data_i,
  output logic [2:0]       phase_o,
  output logic [RND_W-1:0] round_o,
  output logic [IDX_W-1:0] sk_idx_o,
  output logic             half_swap_o,
  output logic             done_o,
  output logic [BLK_W-1:0] data_o
);

  phase_e           ph;
  logic             load, dec_lat, swap;
  logic [IDX_W-1:0] idx;
  logic [BLK_W-1:0] st_q, st_nxt, sk;
  logic [KEY_W-1:0] key_q;

  fs_seq_ctrl #(
    .GRP   (GRP_LEN),
    .RND_S (RND_SHORT),
    .RND_L (RND_LONG),
    .RND_W (RND_W),
    .IDX_W (IDX_W)
  ) u_ctrl (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .start_i     (start_i),
    .key_len_i   (key_len_i),
    .decrypt_i   (decrypt_i),
    .phase_o     (ph),
    .round_o     (round_o),
    .sk_idx_o    (idx),
    .half_swap_o (swap),
    .done_o      (done_o),
    .load_o      (load),
    .dec_o       (dec_lat)
  );

  fs_subkey #(.IDX_W(IDX_W)) u_sk (
    .key_i (key_q),
    .idx_i (idx),
    .sk_o  (sk)
  );

  fs_round_dp u_dp (
    .state_i (st_q),
    .sk_i    (sk),
    .phase_i (ph),
    .swap_i  (swap),
    .dec_i   (dec_lat),
    .next_o  (st_nxt)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q  <= '0;
      key_q <= '0;
    end else if (load) begin
      st_q  <= data_i;
      key_q <= key_i & key_mask(key_len_i);
    end else if (ph != PH_IDLE) begin
      st_q  <= st_nxt;
    end
  end

  assign phase_o     = ph;
  assign sk_idx_o    = idx;
  assign half_swap_o = swap;
  assign data_o      = st_q;

endmodule

// File: rtl/fs_seq_chk.sv
module fs_seq_chk #(
  parameter int GRP   = 6,
  parameter int RND_W = 5,
  parameter int IDX_W = 5,
  parameter int BLK_W = 128
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             start_i,
  input logic [2:0]       phase_o,
  input logic [RND_W-1:0] round_o,
  input logic [IDX_W-1:0] sk_idx_o,
  input logic             half_swap_o,
  input logic             done_o,
  input logic [BLK_W-1:0] data_o,
  input logic             dec_lat
);

  localparam logic [2:0] IDLE = 3'd0, PRE = 3'd1, RND = 3'd2, FL = 3'd3, POST = 3'd4;

  a_r6_start_when_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (phase_o == IDLE && start_i) |=> phase_o == PRE);

  a_r6_no_restart: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (phase_o != IDLE) |=> phase_o != PRE);

  a_r3_layer_on_group: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (phase_o == FL) |-> (round_o != '0 && (int'(round_o) % GRP) == 0));

  a_r3_layer_then_round: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (phase_o == FL) |=> (phase_o == RND && round_o == RND_W'($past(round_o) + 1'b1)));

  a_r4_idx_up: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (phase_o != IDLE && phase_o != POST && !dec_lat) |=> sk_idx_o == IDX_W'($past(sk_idx_o) + 1'b1));

  a_r4_idx_down: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (phase_o != IDLE && phase_o != POST && dec_lat) |=> sk_idx_o == IDX_W'($past(sk_idx_o) - 1'b1));

  a_r5_swap_in_round: assert property (@(posedge clk_i) disable iff (!rst_ni)
    half_swap_o |-> phase_o == RND);

  a_r9_done_after_post: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (phase_o == POST) |=> (done_o && phase_o == IDLE));

  a_r9_done_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  a_r9_hold_result: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (phase_o == IDLE && !start_i) |=> $stable(data_o));

endmodule

bind feistel_round_seq fs_seq_chk #(
  .GRP   (GRP_LEN),
  .RND_W (RND_W),
  .IDX_W (IDX_W),
  .BLK_W (feistel_seq_pkg::BLK_W)
) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .start_i     (start_i),
  .phase_o     (phase_o),
  .round_o     (round_o),
  .sk_idx_o    (sk_idx_o),
  .half_swap_o (half_swap_o),
  .done_o      (done_o),
  .data_o      (data_o),
  .dec_lat     (dec_lat)
);

// File: tb/sim_feistel_round_seq.sv
module sim_feistel_round_seq;

  logic         clk_i = 1'b0;
  logic         rst_ni = 1'b0;
  logic         start_i = 1'b0;
  logic [1:0]   key_len_i = '0;
  logic         decrypt_i = 1'b0;
  logic [255:0] key_i = '0;
  logic [127:0] data_i = '0;
  logic [2:0]   phase_o;
  logic [4:0]   round_o;
  logic [4:0]   sk_idx_o;
  logic         half_swap_o;
  logic         done_o;
  logic [127:0] data_o;

  always #2 clk_i = ~clk_i;

  feistel_round_seq u0 (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .start_i     (start_i),
    .key_len_i   (key_len_i),
    .decrypt_i   (decrypt_i),
    .key_i       (key_i),
    .data_i      (data_i),
    .phase_o     (phase_o),
    .round_o     (round_o),
    .sk_idx_o    (sk_idx_o),
    .half_swap_o (half_swap_o),
    .done_o      (done_o),
    .data_o      (data_o)
  );

  typedef struct {
    int           n;
    int           t;
    bit           dec;
    bit           chk;
    logic [127:0] exp;
  } item_t;

  item_t        sb_q[$];
  int           checks = 0;
  int           errors = 0;
  int           ops_done = 0;
  logic [127:0] last_res;
  bit           finished = 1'b0;

  task automatic chk(input bit ok, input string req, input string what, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic chk128(input bit eq, input string req, input string what, input logic [127:0] act, input logic [127:0] exp);
    checks++;
    if ((act == exp) != eq) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %s%h", req, what, act, eq ? "" : "not ", exp);
    end
  endtask

  // expected phase and round at active cycle j
  function automatic void exp_at(input int j, input int n, input int t, output int ph, output int rn);
    int p;
    if (j == 0) begin ph = 1; rn = 0; end
    else if (j == t - 1) begin ph = 4; rn = n; end
    else begin
      p = j - 1;
      if (p % 7 == 6) begin ph = 3; rn = (p / 7 + 1) * 6; end
      else begin ph = 2; rn = (p / 7) * 6 + p % 7 + 1; end
    end
  endfunction

  // monitor: pops one expected item per operation
  initial begin
    forever begin
      @(negedge clk_i);
      if (phase_o == 3'd1) begin
        item_t it;
        int    j, eph, ern, eidx, nfl;
        bit    seq_ok, idx_ok, sw_ok, esw;
        seq_ok = 1; idx_ok = 1; sw_ok = 1; nfl = 0; j = 0;
        it = '{n: 0, t: 0, dec: 0, chk: 0, exp: '0};
        if (sb_q.size() == 0) chk(0, "R6", "operation without accepted start", 1, 0);
        else it = sb_q.pop_front();
        while (phase_o != 3'd0 && j < 40) begin
          exp_at(j, it.n, it.t, eph, ern);
          if (int'(phase_o) != eph || int'(round_o) != ern) begin
            if (seq_ok) $display("FAIL R3 cycle %0d: actual phase %0d round %0d expected phase %0d round %0d",
                                 j, phase_o, round_o, eph, ern);
            seq_ok = 0;
          end
          eidx = it.dec ? it.t - 1 - j : j;
          if (int'(sk_idx_o) != eidx) begin
            if (idx_ok) $display("FAIL R4 cycle %0d: actual index %0d expected %0d", j, sk_idx_o, eidx);
            idx_ok = 0;
          end
          esw = (eph == 2) && (ern != it.n);
          if (half_swap_o != esw) begin
            if (sw_ok) $display("FAIL R5 cycle %0d: actual swap %0d expected %0d", j, half_swap_o, esw);
            sw_ok = 0;
          end
          if (phase_o == 3'd3) nfl++;
          j++;
          @(negedge clk_i);
        end
        chk(j == it.t, "R2", "active cycle count", j, it.t);
        chk(seq_ok, "R3", "phase/round sequence", seq_ok, 1);
        chk(nfl == it.n / 6 - 1, "R3", "mixing layer count", nfl, it.n / 6 - 1);
        chk(idx_ok, "R4", "subkey index order", idx_ok, 1);
        chk(sw_ok, "R5", "half swap flag", sw_ok, 1);
        chk(done_o == 1'b1, "R9", "done after output whitening", done_o, 1);
        if (it.chk) chk128(1, "R7", "result block", data_o, it.exp);
        last_res = data_o;
        ops_done++;
        @(negedge clk_i);
        chk(done_o == 1'b0, "R9", "done is one cycle", done_o, 0);
        chk(phase_o == 3'd0, "R6", "idle after operation", phase_o, 0);
      end
    end
  end

  // driver: mode 0 plain, 1 extra start mid-run, 2 extra start in output whitening
  task automatic run_op(input logic [1:0] kl, input bit dc, input logic [255:0] k,
                        input logic [127:0] d, input bit ck, input logic [127:0] ex, input int mode);
    item_t it;
    int    target;
    it.n   = (kl == 2'd0) ? 18 : 24;
    it.t   = it.n + it.n / 6 + 1;
    it.dec = dc;
    it.chk = ck;
    it.exp = ex;
    target = ops_done + 1;
    @(posedge clk_i); #1;
    key_len_i = kl; decrypt_i = dc; key_i = k; data_i = d; start_i = 1'b1;
    sb_q.push_back(it);
    @(posedge clk_i); #1;
    start_i = 1'b0;
    key_len_i = ~kl; decrypt_i = ~dc; key_i = ~k; data_i = ~d;
    if (mode != 0) begin
      repeat ((mode == 1) ? 4 : it.t - 1) @(posedge clk_i);
      #1 start_i = 1'b1; data_i = d ^ 128'h1;
      @(posedge clk_i); #1 start_i = 1'b0;
    end
    while (ops_done < target) @(negedge clk_i);
  endtask

  initial begin
    repeat (150000) @(posedge clk_i);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog: actual running expected finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [255:0] k1, k2;
    logic [127:0] p1, p2, c1, c2, c3;
    k1 = 256'h0f1e2d3c4b5a6978_8796a5b4c3d2e1f0_0123456789abcdef_fedcba9876543210;
    k2 = 256'h1122334455667788_99aabbccddeeff00_a5a55a5a3c3cc3c3_0f0ff0f0deadbeef;
    p1 = 128'h00112233445566778899aabbccddeeff;
    p2 = 128'hcafef00d12345678feedface87654321;

    repeat (3) @(negedge clk_i);
    chk(phase_o == 3'd0, "R1", "reset phase", phase_o, 0);
    chk(done_o == 1'b0, "R1", "reset done", done_o, 0);
    @(negedge clk_i); rst_ni = 1'b1;
    repeat (2) @(negedge clk_i);
    chk(phase_o == 3'd0 && round_o == 5'd0, "R1", "idle after reset", phase_o, 0);
    chk128(1, "R1", "data after reset", data_o, '0);

    // R7 round trip for each key length, R2 lengths
    run_op(2'd0, 0, k1, p1, 0, '0, 0); c1 = last_res;
    chk128(0, "R7", "ciphertext 128 differs", c1, p1);
    run_op(2'd0, 1, k1, c1, 1, p1, 0);
    run_op(2'd1, 0, k2, p2, 0, '0, 0); c2 = last_res;
    chk128(0, "R7", "ciphertext 192 differs", c2, p2);
    run_op(2'd1, 1, k2, c2, 1, p2, 0);
    run_op(2'd2, 0, k1, p2, 0, '0, 0); c3 = last_res;
    run_op(2'd2, 1, k1, c3, 1, p2, 0);
    // R2: code 3 behaves as 256-bit
    run_op(2'd3, 0, k1, p2, 1, c3, 0);

    // R8 unused key bits
    run_op(2'd0, 0, {~k1[255:128], k1[127:0]}, p1, 1, c1, 0);
    run_op(2'd1, 0, {~k2[255:192], k2[191:0]}, p2, 1, c2, 0);
    run_op(2'd2, 0, {~k1[255:192], k1[191:0]}, p2, 0, '0, 0);
    chk128(0, "R8", "256-bit key uses top bits", last_res, c3);

    // R6 start pulses while busy
    run_op(2'd0, 0, k1, p1, 1, c1, 1);
    run_op(2'd0, 0, k1, p1, 1, c1, 2);
    run_op(2'd2, 1, k1, c3, 1, p2, 1);

    // R9 result held while idle
    repeat (6) @(negedge clk_i);
    chk128(1, "R9", "result held", data_o, p2);
    chk(done_o == 1'b0 && phase_o == 3'd0, "R9", "idle without start", phase_o, 0);

    finished = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule